// File: doc/BRIEF.md
# Clock Update Sequencer

This block paces the once-per-second advance of a real-time clock's time and calendar counters. It counts timebase ticks from a sub-second divider and issues a one-cycle advance strobe to the counter logic each time a full second has elapsed. A 3-bit control field sets how the oscillator and the divider behave. The oscillator can run with the divider counting, run with the divider held at its restart point, or stop with the divider frozen where it is.

Around each advance the block drives the status a host needs to read the counters without tearing. An update-in-progress bit goes high a fixed number of ticks before the strobe and drops once the update is done. While that bit reads 0, the host is sure of at least that many ticks before any counter changes. The end of each update sets a sticky update-ended flag. It also raises an interrupt request when the update interrupt is enabled and transfers are not inhibited. A single read-clear strobe clears both.

Top module: `rtc_update_seq`

## Requirements
- R1: With control field 3'b010 and a tick on every cycle, `adv_o` pulses high for exactly one cycle every TICKS_PER_SEC ticks.
- R2: Control values 3'b110 and 3'b111 hold the divider at its restart point, so `adv_o` stays low. After the field returns to 3'b010, the first `adv_o` comes TICKS_PER_SEC/2 ticks later.
- R3: Any control value other than 3'b010, 3'b110 and 3'b111 stops the oscillator. The divider then freezes with its count kept, `adv_o` and `uip_o` stay low, and on return to 3'b010 the count resumes from where it stopped.
- R4: The divider advances only on cycles where `tick_i` is 1. With `tick_i` held at 0, no `adv_o` occurs and the remaining count is kept.
- R5: `uip_o` is high for exactly UIP_LEAD_TICKS ticks before the `adv_o` cycle, stays high during that cycle, and is low in the cycle after it.
- R6: `uf_o` goes to 1 in the cycle after `adv_o` and stays set until a `flag_clr_i` pulse. If a clear coincides with the `adv_o` cycle, the set wins.
- R7: `irq_o` goes to 1 in the cycle after `adv_o` only if `uie_i` = 1 and `uti_i` = 0 during the `adv_o` cycle. It is cleared by `flag_clr_i`.
- R8: During reset all outputs are 0. After reset is released with 3'b010 and a tick every cycle, the first `adv_o` comes TICKS_PER_SEC/2 ticks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Timebase tick enable, one per divider step |
| osc_ctrl_i | input | 3 | Oscillator and divider control field |
| uie_i | input | 1 | Update interrupt enable |
| uti_i | input | 1 | Update transfer inhibit |
| flag_clr_i | input | 1 | Read-clear strobe for flag and request |
| uip_o | output | 1 | Update-in-progress status |
| uf_o | output | 1 | Sticky update-ended flag |
| irq_o | output | 1 | Update interrupt request |
| adv_o | output | 1 | One-cycle strobe telling the counters to advance |

## Verification
A corrupted divider count shows up as a strobe that comes at the wrong distance from the previous one or from a control change. The interval measurements catch it within one second of ticks. A wrong mode decode shows up as a strobe while the field holds a stop or hold pattern, or as a restart when a resume was expected. A fault in the update-in-progress window or the flags shows up in the cycle next to the strobe. The bench samples there.

// File: rtl/rtc_upd_pkg.sv
// Package: shared mode type for the clock update sequencer.
// Assumes: a 3-bit control field; only the listed encodings are decoded.
package rtc_upd_pkg;

    typedef enum logic [1:0] {
        MODE_STOP = 2'd0,   // oscillator off, divider frozen
        MODE_HOLD = 2'd1,   // oscillator on, divider held at restart
        MODE_RUN  = 2'd2    // oscillator and divider both running
    } osc_mode_e;

    // Maps the raw control field to an operating mode.
    function automatic osc_mode_e decode_ctrl(input logic [2:0] ctrl);
        if (ctrl == 3'b010)
            return MODE_RUN;
        else if (ctrl[2:1] == 2'b11)
            return MODE_HOLD;
        else
            return MODE_STOP;
    endfunction

endpackage

// File: rtl/rtc_osc_decode.sv
// Module: rtc_osc_decode
// Turns the oscillator/divider control field into a mode.
// Assumes: the field is stable in the host clock domain.
module rtc_osc_decode
    import rtc_upd_pkg::*;
(
    input  logic [2:0] ctrl_i,
    output osc_mode_e  mode_o
);

    // Purpose: pure decode, no state.
    always_comb begin
        mode_o = decode_ctrl(ctrl_i);
    end

endmodule

// File: rtl/rtc_tick_div.sv
// Module: rtc_tick_div
// Sub-second divider. It counts down the ticks left to the next update,
// issues a one-cycle advance strobe and drives the update-in-progress warning.
// Assumes: TICKS_PER_SEC/2 > UIP_LEAD_TICKS >= 1.
module rtc_tick_div
    import rtc_upd_pkg::*;
#(
    parameter int unsigned TICKS_PER_SEC  = 4096,
    parameter int unsigned UIP_LEAD_TICKS = 1
) (
    input  logic      clk_i,
    input  logic      rst_ni,
    input  logic      tick_i,
    input  osc_mode_e mode_i,
    output logic      adv_o,
    output logic      uip_o
);

    localparam int unsigned CW = $clog2(TICKS_PER_SEC + 1);
    localparam logic [CW-1:0] FULL_C = CW'(TICKS_PER_SEC);
    localparam logic [CW-1:0] HALF_C = CW'(TICKS_PER_SEC / 2);
    localparam logic [CW-1:0] LEAD_C = CW'(UIP_LEAD_TICKS);
    localparam logic [CW-1:0] ONE_C  = CW'(1);

    logic [CW-1:0] left_q;
    logic          adv_q;

    // Purpose: count down the ticks left and fire the strobe at the last one.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            left_q <= HALF_C;
            adv_q  <= 1'b0;
        end else begin
            adv_q <= 1'b0;
            if (mode_i == MODE_HOLD) begin
                left_q <= HALF_C;
            end else if (mode_i == MODE_RUN && tick_i) begin
                if (left_q == ONE_C) begin
                    left_q <= FULL_C;
                    adv_q  <= 1'b1;
                end else begin
                    left_q <= left_q - ONE_C;
                end
            end
        end
    end

    // Purpose: warn inside the lead window and through the strobe cycle.
    always_comb begin
        uip_o = ((mode_i == MODE_RUN) && (left_q <= LEAD_C)) || adv_q;
        adv_o = adv_q;
    end

endmodule

// File: rtl/rtc_upd_flags.sv
// Module: rtc_upd_flags
// Sticky update-ended flag and gated interrupt request, both read-cleared.
// Assumes: adv_i is a one-cycle strobe; a set beats a coincident clear.
module rtc_upd_flags (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic adv_i,
    input  logic uie_i,
    input  logic uti_i,
    input  logic clr_i,
    output logic uf_o,
    output logic irq_o
);

    // Purpose: latch the end of each update until the host clears it.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)
            uf_o <= 1'b0;
        else if (adv_i)
            uf_o <= 1'b1;
        else if (clr_i)
            uf_o <= 1'b0;
    end

    // Purpose: raise a request only when enabled and transfers not inhibited.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)
            irq_o <= 1'b0;
        else if (adv_i && uie_i && !uti_i)
            irq_o <= 1'b1;
        else if (clr_i)
            irq_o <= 1'b0;
    end

endmodule

// File: rtl/rtc_update_seq.sv
// Module: rtc_update_seq (top)
// Sequences the once-per-second clock update: mode decode, sub-second
// divider with warning window, and the host flags.
// Assumes: tick_i is a one-cycle enable at the timebase rate.
module rtc_update_seq
    import rtc_upd_pkg::*;
#(
    parameter int unsigned TICKS_PER_SEC  = 4096,
    parameter int unsigned UIP_LEAD_TICKS = 1
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       tick_i,
    input  logic [2:0] osc_ctrl_i,
    input  logic       uie_i,
    input  logic       uti_i,
    input  logic       flag_clr_i,
    output logic       uip_o,
    output logic       uf_o,
    output logic       irq_o,
    output logic       adv_o
);

    osc_mode_e mode_w;
    logic      adv_w;

    rtc_osc_decode dec_i (
        .ctrl_i (osc_ctrl_i),
        .mode_o (mode_w)
    );

    rtc_tick_div #(
        .TICKS_PER_SEC  (TICKS_PER_SEC),
        .UIP_LEAD_TICKS (UIP_LEAD_TICKS)
    ) div_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .tick_i (tick_i),
        .mode_i (mode_w),
        .adv_o  (adv_w),
        .uip_o  (uip_o)
    );

    rtc_upd_flags flg_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .adv_i  (adv_w),
        .uie_i  (uie_i),
        .uti_i  (uti_i),
        .clr_i  (flag_clr_i),
        .uf_o   (uf_o),
        .irq_o  (irq_o)
    );

    assign adv_o = adv_w;

endmodule

// File: rtl/rtc_update_seq_chk.sv
// Module: rtc_update_seq_chk
// Port-level checker bound to rtc_update_seq.
module rtc_update_seq_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic [2:0] osc_ctrl_i,
    input logic       uie_i,
    input logic       uti_i,
    input logic       flag_clr_i,
    input logic       uip_o,
    input logic       uf_o,
    input logic       irq_o,
    input logic       adv_o
);

    p_adv_one_cycle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        adv_o |=> !adv_o);

    p_held_no_adv_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (osc_ctrl_i != 3'b010) |=> !adv_o);

    p_stop_no_uip_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (osc_ctrl_i != 3'b010) |-> (!uip_o || adv_o));

    p_adv_in_uip_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        adv_o |-> uip_o);

    p_uf_after_adv_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        adv_o |=> uf_o);

    p_irq_gated_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(irq_o) |-> ($past(adv_o) && $past(uie_i) && !$past(uti_i)));

    p_irq_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flag_clr_i && !adv_o) |=> !irq_o);

endmodule

bind rtc_update_seq rtc_update_seq_chk chk_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .osc_ctrl_i (osc_ctrl_i),
    .uie_i      (uie_i),
    .uti_i      (uti_i),
    .flag_clr_i (flag_clr_i),
    .uip_o      (uip_o),
    .uf_o       (uf_o),
    .irq_o      (irq_o),
    .adv_o      (adv_o)
);

// File: tb/rtc_update_seq_tb_top.sv
module rtc_update_seq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int TPS  = 16;
    localparam int LEAD = 2;
    localparam int HALF = TPS / 2;

    // Vectors {uie, uti, expected irq}
    localparam logic [2:0] VEC [5] = '{3'b101, 3'b110, 3'b000, 3'b010, 3'b101};

    logic       clk = 1'b0;
    logic       rst_n;
    logic       tick;
    logic [2:0] ctrl;
    logic       uie, uti, clr;
    logic       uip, uf, irq, adv;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rtc_update_seq #(.TICKS_PER_SEC(TPS), .UIP_LEAD_TICKS(LEAD)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .osc_ctrl_i(ctrl),
        .uie_i(uie), .uti_i(uti), .flag_clr_i(clr),
        .uip_o(uip), .uf_o(uf), .irq_o(irq), .adv_o(adv)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_adv(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!adv && n < 200);
    endtask

    task automatic quiet(input int cycles, input string req);
        int bad = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (adv || uip) bad++;
        end
        chk(bad == 0, req, bad, 0);
    endtask

    initial begin
        int n;
        int u;
        rst_n = 1'b0; tick = 1'b1; ctrl = 3'b010;
        uie = 1'b0; uti = 1'b0; clr = 1'b0;
        repeat (3) @(negedge clk);
        chk({uip, uf, irq, adv} == 4'b0, "R8 reset outputs", {uip, uf, irq, adv}, 0);
        rst_n = 1'b1;
        wait_adv(n);
        chk(n == HALF, "R8 first update after reset", n, HALF);

        // R1/R5: period and warning window
        n = 0; u = 0;
        do begin
            @(negedge clk);
            n++;
            if (!adv && uip) u++;
        end while (!adv && n < 200);
        chk(n == TPS, "R1 update period", n, TPS);
        chk(u == LEAD, "R5 uip lead ticks", u, LEAD);
        chk(uip == 1'b1, "R5 uip high in strobe cycle", uip, 1);
        @(negedge clk);
        chk(adv == 1'b0, "R1 strobe one cycle", adv, 0);
        chk(uip == 1'b0, "R5 uip low after update", uip, 0);
        chk(uf == 1'b1, "R6 flag set after update", uf, 1);

        // R7 table walk
        for (int v = 0; v < 5; v++) begin
            uie = VEC[v][2]; uti = VEC[v][1]; clr = 1'b1;
            @(negedge clk);
            clr = 1'b0;
            chk(uf == 1'b0, "R6 clear", uf, 0);
            wait_adv(n);
            @(negedge clk);
            chk(uf == 1'b1, "R6 flag per update", uf, 1);
            chk(irq == VEC[v][0], "R7 request gating", irq, VEC[v][0]);
        end
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        chk(uf == 1'b0 && irq == 1'b0, "R7 read-clear", {uf, irq}, 0);

        // R3: stop pattern keeps the count
        wait_adv(n);
        repeat (5) @(negedge clk);
        ctrl = 3'b101;
        quiet(30, "R3 stopped no activity");
        ctrl = 3'b010;
        wait_adv(n);
        chk(n == TPS - 5, "R3 count resumes", n, TPS - 5);

        // R4: no tick, no progress
        tick = 1'b0;
        quiet(40, "R4 no ticks no update");
        tick = 1'b1;
        wait_adv(n);
        chk(n == TPS, "R4 count kept without ticks", n, TPS);

        // R2: hold pattern restarts the divider
        repeat (3) @(negedge clk);
        ctrl = 3'b111;
        quiet(40, "R2 held no activity");
        ctrl = 3'b010;
        wait_adv(n);
        chk(n == HALF, "R2 half second after release", n, HALF);

        // R6: set beats coincident clear
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        wait_adv(n);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        chk(uf == 1'b1, "R6 set wins over clear", uf, 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule